// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block stores incoming frames into a circular region of byte-addressed buffer memory. The memory is split into 256-byte pages (2^OFS_W bytes per page). The ring covers the pages from a configured first page up to, but not including, a configured stop page. The block keeps a current-page pointer, which marks where the next frame will begin. It also holds a boundary pointer that the host moves as it consumes frames.

Each frame is placed four bytes into its first page, leaving room for a header. When the last byte arrives without error, the block goes back and fills in the header: a status byte, the page where the following frame will start, and a 16-bit count equal to the payload length plus four. It then moves the current page to that next page. If a frame would spill into the boundary page, the block discards the rest of that frame, raises an overwrite pulse and enters a halted state. In the halted state every frame is dropped until the host moves the boundary.

A monitor mode lets frames pass through without being stored. Consecutive frames must be at least five idle cycles apart, because the header is written in the four cycles that follow the last byte. The block ignores input bytes during those four cycles.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, cur_page and bnd_page are 0, halted is 0, and mem_we and all three pulses are 0.
- R2: A page pointer stepped from stop-1 goes to the first page, so every memory write targets a page in [first, stop).
- R3: Payload byte i of a frame is written at page offset (4+i) counted linearly from the frame's first page, wrapping per R2.
- R4: The header of a good frame holds, at page offsets 0..3 of its first page: the input flags with bit 0 forced to 1, the next-packet page, and then the count (payload length + 4) low byte followed by the high byte.
- R5: After a good frame, cur_page becomes the next-packet page, which is the page after the page holding the last byte. pkt_pulse is high for the one cycle in which the last header byte (offset 3) is presented on the memory port.
- R6: A frame ended with rx_bad set gets no header write, leaves cur_page unchanged and raises no pkt_pulse.
- R7: Any byte that would be the first byte written into the boundary page triggers an overrun. On an overrun, ovw_pulse and miss_pulse fire, halted is set, no byte of the frame is stored from that point on, and cur_page is kept.
- R8: While halted is 1, whole frames are dropped without memory writes, and miss_pulse fires at their last byte.
- R9: A boundary write (register address 2) of a value different from the stored one clears halted, and a write of the same value does not. When an overrun and such a write fall in the same cycle, halted ends up set and the boundary still takes the new value.
- R10: With the mode register (address 4) bit 0 set, frames cause no memory writes and no pkt_pulse, leave cur_page unchanged, and fire miss_pulse at their last byte.

Register addresses on cfg_addr: 0 first page, 1 stop page, 2 boundary, 3 current page, 4 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | PAGE_W | Register write value |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_bad | input | 1 | Frame error, valid with rx_eof |
| rx_flags | input | 8 | Receive status, valid with rx_eof |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | PAGE_W+OFS_W | Buffer memory byte address {page, offset} |
| mem_wdata | output | 8 | Buffer memory write data |
| cur_page | output | PAGE_W | Current-page pointer |
| bnd_page | output | PAGE_W | Boundary pointer |
| halted | output | 1 | Set on overrun, cleared by a boundary move |
| pkt_pulse | output | 1 | Good frame stored |
| miss_pulse | output | 1 | Frame not stored |
| ovw_pulse | output | 1 | Ring overrun detected |

## Verification
The overrun decision and a host boundary update can fall in the same clock edge: one sets the halted state and the other clears it. The bench provokes this by placing the boundary on the current page and then driving the first byte of a frame in the same cycle as a boundary write of a new value. It expects halted to be set, the overwrite pulse to have fired, no write to have been made, and the boundary to read back the new value. A later write of a further distinct value must then release the halt.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_HDR
  } rrb_state_e;

  localparam logic [2:0] REG_FIRST = 3'd0;
  localparam logic [2:0] REG_STOP  = 3'd1;
  localparam logic [2:0] REG_BND   = 3'd2;
  localparam logic [2:0] REG_CUR   = 3'd3;
  localparam logic [2:0] REG_MODE  = 3'd4;

  localparam int HDR_LEN = 4;
  localparam int CNT_W   = 16;
endpackage

// File: rtl/rrb_pgstep.sv
// Steps a page number by one inside the ring [first, stop).
module rrb_pgstep #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] pg_i,
  input  logic [PAGE_W-1:0] first_i,
  input  logic [PAGE_W-1:0] stop_i,
  output logic [PAGE_W-1:0] pg_o
);
  logic [PAGE_W-1:0] last_pg;

  always_comb begin
    last_pg = stop_i - PAGE_W'(1);
    pg_o    = (pg_i == last_pg) ? first_i : pg_i + PAGE_W'(1);
  end
endmodule

// File: rtl/rrb_regs.sv
// Ring pointers, mode bit and the halted flag.
module rrb_regs
  import rrb_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              adv_en,
  input  logic [PAGE_W-1:0] adv_page,
  input  logic              ovw_set,
  output logic [PAGE_W-1:0] first_pg,
  output logic [PAGE_W-1:0] stop_pg,
  output logic [PAGE_W-1:0] bnd_pg,
  output logic [PAGE_W-1:0] cur_pg,
  output logic              mon,
  output logic              halted
);
  logic bnd_moved;

  assign bnd_moved = cfg_we && (cfg_addr == REG_BND) && (cfg_wdata != bnd_pg);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_pg <= '0;
      stop_pg  <= '0;
      bnd_pg   <= '0;
      mon      <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_FIRST: first_pg <= cfg_wdata;
        REG_STOP:  stop_pg  <= cfg_wdata;
        REG_BND:   bnd_pg   <= cfg_wdata;
        REG_MODE:  mon      <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  // Ring advance takes precedence over a host write of the current page.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pg <= '0;
    end else if (adv_en) begin
      cur_pg <= adv_page;
    end else if (cfg_we && cfg_addr == REG_CUR) begin
      cur_pg <= cfg_wdata;
    end
  end

  // An overrun in the same cycle as a boundary move leaves the flag set.
  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
    end else if (ovw_set) begin
      halted <= 1'b1;
    end else if (bnd_moved) begin
      halted <= 1'b0;
    end
  end
endmodule

// File: rtl/rrb_ctrl.sv
// Frame sequencing: payload placement, overrun check, header write-back.
module rrb_ctrl
  import rrb_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_eof,
  input  logic                    rx_bad,
  input  logic [7:0]              rx_flags,
  input  logic [PAGE_W-1:0]       first_pg,
  input  logic [PAGE_W-1:0]       stop_pg,
  input  logic [PAGE_W-1:0]       bnd_pg,
  input  logic [PAGE_W-1:0]       cur_pg,
  input  logic                    mon,
  input  logic                    halted,
  output logic                    mem_we,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic                    adv_en,
  output logic [PAGE_W-1:0]       adv_page,
  output logic                    ovw_set,
  output logic                    pkt_pulse,
  output logic                    miss_pulse,
  output logic                    ovw_pulse
);
  localparam logic [OFS_W-1:0] HDR_OFS  = OFS_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HDR_LEN + 1);

  rrb_state_e        state_q;
  logic [PAGE_W-1:0] wpg_q, nxt_q, tgt_pg, stp_pg;
  logic [OFS_W-1:0]  wofs_q, tgt_ofs;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        stat_q, hdr_byte;
  logic [1:0]        hidx_q;
  logic              dmiss_q;
  logic              fresh, store_ok, overrun, take;

  // Address the next byte would land at; a fresh page needs the boundary check.
  always_comb begin
    if (state_q == ST_IDLE) begin
      tgt_pg  = cur_pg;
      tgt_ofs = HDR_OFS;
      fresh   = 1'b1;
    end else begin
      tgt_pg  = wpg_q;
      tgt_ofs = wofs_q;
      fresh   = (wofs_q == '0);
    end
    store_ok = (state_q == ST_DATA) || (state_q == ST_IDLE && !mon && !halted);
    overrun  = rx_valid && store_ok && fresh && (tgt_pg == bnd_pg);
    take     = rx_valid && store_ok && !overrun;
  end

  rrb_pgstep #(.PAGE_W(PAGE_W)) step_i (
    .pg_i    (tgt_pg),
    .first_i (first_pg),
    .stop_i  (stop_pg),
    .pg_o    (stp_pg)
  );

  always_comb begin
    case (hidx_q)
      2'd0:    hdr_byte = stat_q;
      2'd1:    hdr_byte = 8'(nxt_q);
      2'd2:    hdr_byte = cnt_q[7:0];
      default: hdr_byte = cnt_q[15:8];
    endcase
  end

  assign ovw_set  = overrun;
  assign adv_en   = (state_q == ST_HDR) && (hidx_q == 2'd3);
  assign adv_page = nxt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      wpg_q      <= '0;
      wofs_q     <= '0;
      nxt_q      <= '0;
      cnt_q      <= '0;
      stat_q     <= '0;
      hidx_q     <= '0;
      dmiss_q    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      pkt_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
      ovw_pulse  <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      pkt_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
      ovw_pulse  <= 1'b0;
      if (take) begin
        mem_we    <= 1'b1;
        mem_addr  <= {tgt_pg, tgt_ofs};
        mem_wdata <= rx_data;
        cnt_q     <= (state_q == ST_IDLE) ? CNT_INIT : cnt_q + CNT_W'(1);
        wofs_q    <= tgt_ofs + OFS_W'(1);
        wpg_q     <= (tgt_ofs == '1) ? stp_pg : tgt_pg;
        if (rx_eof) begin
          nxt_q   <= stp_pg;
          stat_q  <= rx_flags | 8'h01;
          hidx_q  <= 2'd0;
          state_q <= rx_bad ? ST_IDLE : ST_HDR;
        end else begin
          state_q <= ST_DATA;
        end
      end else if (overrun) begin
        ovw_pulse  <= 1'b1;
        miss_pulse <= 1'b1;
        dmiss_q    <= 1'b0;
        state_q    <= rx_eof ? ST_IDLE : ST_DROP;
      end else if (rx_valid && state_q == ST_IDLE) begin
        if (rx_eof) begin
          miss_pulse <= 1'b1;
        end else begin
          dmiss_q <= 1'b1;
          state_q <= ST_DROP;
        end
      end else if (rx_valid && rx_eof && state_q == ST_DROP) begin
        miss_pulse <= dmiss_q;
        state_q    <= ST_IDLE;
      end else if (state_q == ST_HDR) begin
        mem_we    <= 1'b1;
        mem_addr  <= {cur_pg, OFS_W'(hidx_q)};
        mem_wdata <= hdr_byte;
        hidx_q    <= hidx_q + 2'd1;
        if (hidx_q == 2'd3) begin
          pkt_pulse <= 1'b1;
          state_q   <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [PAGE_W-1:0]       cfg_wdata,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_eof,
  input  logic                    rx_bad,
  input  logic [7:0]              rx_flags,
  output logic                    mem_we,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PAGE_W-1:0]       cur_page,
  output logic [PAGE_W-1:0]       bnd_page,
  output logic                    halted,
  output logic                    pkt_pulse,
  output logic                    miss_pulse,
  output logic                    ovw_pulse
);
  logic [PAGE_W-1:0] first_pg, stop_pg, adv_page;
  logic              mon, adv_en, ovw_set;

  rrb_regs #(.PAGE_W(PAGE_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .adv_en    (adv_en),
    .adv_page  (adv_page),
    .ovw_set   (ovw_set),
    .first_pg  (first_pg),
    .stop_pg   (stop_pg),
    .bnd_pg    (bnd_page),
    .cur_pg    (cur_page),
    .mon       (mon),
    .halted    (halted)
  );

  rrb_ctrl #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_eof     (rx_eof),
    .rx_bad     (rx_bad),
    .rx_flags   (rx_flags),
    .first_pg   (first_pg),
    .stop_pg    (stop_pg),
    .bnd_pg     (bnd_page),
    .cur_pg     (cur_page),
    .mon        (mon),
    .halted     (halted),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .adv_en     (adv_en),
    .adv_page   (adv_page),
    .ovw_set    (ovw_set),
    .pkt_pulse  (pkt_pulse),
    .miss_pulse (miss_pulse),
    .ovw_pulse  (ovw_pulse)
  );
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_we,
  input logic [2:0]              cfg_addr,
  input logic [PAGE_W-1:0]       cfg_wdata,
  input logic                    mem_we,
  input logic [PAGE_W+OFS_W-1:0] mem_addr,
  input logic [PAGE_W-1:0]       cur_page,
  input logic [PAGE_W-1:0]       bnd_page,
  input logic                    halted,
  input logic                    pkt_pulse,
  input logic                    miss_pulse,
  input logic                    ovw_pulse
);
  localparam int AW = PAGE_W + OFS_W;

  // R5: the completion pulse accompanies the last header byte on the old page
  p_hdr_last_r5: assert property (@(posedge clk) disable iff (rst)
    pkt_pulse |-> (mem_we && mem_addr[OFS_W-1:0] == OFS_W'(3) &&
                   mem_addr[AW-1:OFS_W] == $past(cur_page)));

  // R6: the current page moves only on a good frame or a host write
  p_cur_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cur_page != $past(cur_page)) |-> (pkt_pulse || $past(cfg_we && cfg_addr == 3'd3)));

  // R7: an overrun reports a miss and leaves the block halted
  p_ovw_halt_r7: assert property (@(posedge clk) disable iff (rst)
    ovw_pulse |-> (halted && miss_pulse));

  // R8: nothing is written while halted
  p_halt_nowr_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> !mem_we);

  // R9: the halt is released only by moving the boundary
  p_halt_rel_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> ($past(cfg_we) && $past(cfg_addr) == 3'd2 &&
                       $past(cfg_wdata) != $past(bnd_page)));

  // R10: a frame is either stored or missed, never both
  p_pkt_miss_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(pkt_pulse && miss_pulse));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .cur_page   (cur_page),
  .bnd_page   (bnd_page),
  .halted     (halted),
  .pkt_pulse  (pkt_pulse),
  .miss_pulse (miss_pulse),
  .ovw_pulse  (ovw_pulse)
);

// File: tb/rx_ring_mgr_tb_top.sv
`timescale 1ns/1ps
module rx_ring_mgr_tb_top;
  localparam int PW = 8;
  localparam int OW = 8;
  localparam int AW = PW + OW;
  localparam int FIRST = 'h40;
  localparam int STOP  = 'h48;
  localparam int NPG   = STOP - FIRST;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic          rx_valid = 1'b0, rx_eof = 1'b0, rx_bad = 1'b0;
  logic [7:0]    rx_data = '0, rx_flags = '0;
  logic          mem_we, halted, pkt_pulse, miss_pulse, ovw_pulse;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [PW-1:0] cur_page, bnd_page;

  rx_ring_mgr #(.PAGE_W(PW), .OFS_W(OW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_bad(rx_bad),
    .rx_flags(rx_flags), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .bnd_page(bnd_page), .halted(halted), .pkt_pulse(pkt_pulse),
    .miss_pulse(miss_pulse), .ovw_pulse(ovw_pulse)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] mem_model [int];
  int we_cnt = 0, pkt_cnt = 0, miss_cnt = 0, ovw_cnt = 0, outside_cnt = 0, hdrw_cnt = 0;
  int watch_pg = -1;
  int cur_m, bnd_m;

  // Behaves as the buffer memory; sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        mem_model[int'(mem_addr)] = mem_wdata;
        we_cnt++;
        if (int'(mem_addr[AW-1:OW]) < FIRST || int'(mem_addr[AW-1:OW]) >= STOP) outside_cnt++;
        if (int'(mem_addr[OW-1:0]) < 4 && int'(mem_addr[AW-1:OW]) == watch_pg) hdrw_cnt++;
      end
      if (pkt_pulse)  pkt_cnt++;
      if (miss_pulse) miss_cnt++;
      if (ovw_pulse)  ovw_cnt++;
    end
  end

  task automatic chk(string rq, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic int step(int p, int k);
    return FIRST + ((p - FIRST + k) % NPG);
  endfunction

  task automatic cfg_write(int a, int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = PW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(int len, int flags, bit isbad, int seed, bit cfg_first, int cfg_val);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'((seed + i * 7) & 255);
      rx_eof = (i == len - 1); rx_bad = isbad; rx_flags = 8'(flags);
      if (i == 0 && cfg_first) begin
        cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = PW'(cfg_val);
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0; rx_bad = 1'b0; cfg_we = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic good_frame(int len, int flags, int seed, bit release_ring);
    int p0, pages, nxt, errs, pos, a;
    mem_model.delete();
    p0 = pkt_cnt;
    pages = (len + 4 + 255) / 256;
    nxt = step(cur_m, pages);
    send_frame(len, flags, 1'b0, seed, 1'b0, 0);
    chk("R5 cur_page", int'(cur_page) == nxt, int'(cur_page), nxt);
    chk("R5 pkt_pulse", pkt_cnt - p0 == 1, pkt_cnt - p0, 1);
    a = cur_m * 256;
    chk("R4 status", mem_model.exists(a) && int'(mem_model[a]) == ((flags & 254) | 1),
        mem_model.exists(a) ? int'(mem_model[a]) : -1, (flags & 254) | 1);
    chk("R4 next page", mem_model.exists(a + 1) && int'(mem_model[a + 1]) == nxt,
        mem_model.exists(a + 1) ? int'(mem_model[a + 1]) : -1, nxt);
    chk("R4 count lo", mem_model.exists(a + 2) && int'(mem_model[a + 2]) == ((len + 4) & 255),
        mem_model.exists(a + 2) ? int'(mem_model[a + 2]) : -1, (len + 4) & 255);
    chk("R4 count hi", mem_model.exists(a + 3) && int'(mem_model[a + 3]) == ((len + 4) >> 8),
        mem_model.exists(a + 3) ? int'(mem_model[a + 3]) : -1, (len + 4) >> 8);
    errs = 0;
    for (int i = 0; i < len; i++) begin
      pos = 4 + i;
      a = step(cur_m, pos / 256) * 256 + (pos % 256);
      if (!mem_model.exists(a) || int'(mem_model[a]) != ((seed + i * 7) & 255)) errs++;
    end
    chk("R3 R2 payload placement", errs == 0, errs, 0);
    cur_m = nxt;
    if (release_ring) begin
      bnd_m = step(cur_m, NPG - 1);
      cfg_write(2, bnd_m);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, m0, o0, p0, h0;
    int fixed_len [9] = '{1, 2, 251, 252, 253, 508, 509, 764, 1788};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 cur_page", cur_page == '0, int'(cur_page), 0);
    chk("R1 bnd_page", bnd_page == '0, int'(bnd_page), 0);
    chk("R1 halted", halted == 1'b0, int'(halted), 0);
    chk("R1 outputs quiet", !mem_we && !pkt_pulse && !miss_pulse && !ovw_pulse,
        int'(mem_we) + int'(pkt_pulse) + int'(miss_pulse) + int'(ovw_pulse), 0);

    cfg_write(0, FIRST); cfg_write(1, STOP); cfg_write(3, FIRST);
    cur_m = FIRST; bnd_m = step(FIRST, NPG - 1);
    cfg_write(2, bnd_m);

    // R3 R4 R5 R2: sweep of lengths around page edges and across the wrap
    foreach (fixed_len[j]) good_frame(fixed_len[j], (j * 37) & 255, j * 11, 1'b1);
    for (int k = 0; k < 30; k++) good_frame(1 + (k * 173) % 1788, (k * 29) & 255, k * 5 + 3, 1'b1);

    // R7: fill three pages, then a frame needing five of the remaining four
    good_frame(700, 8'h22, 9, 1'b0);
    w0 = we_cnt; m0 = miss_cnt; o0 = ovw_cnt; p0 = pkt_cnt;
    send_frame(1100, 8'h10, 1'b0, 1, 1'b0, 0);
    chk("R7 ovw_pulse", ovw_cnt - o0 == 1, ovw_cnt - o0, 1);
    chk("R7 halted", halted == 1'b1, int'(halted), 1);
    chk("R7 bytes before overrun", we_cnt - w0 == 1020, we_cnt - w0, 1020);
    chk("R7 cur kept", int'(cur_page) == cur_m, int'(cur_page), cur_m);
    chk("R7 miss/no pkt", (miss_cnt - m0 == 1) && (pkt_cnt == p0), miss_cnt - m0, 1);

    // R8: halted drops whole frames
    w0 = we_cnt; m0 = miss_cnt;
    send_frame(10, 0, 1'b0, 2, 1'b0, 0);
    chk("R8 no writes", we_cnt == w0, we_cnt - w0, 0);
    chk("R8 miss_pulse", miss_cnt - m0 == 1, miss_cnt - m0, 1);

    // R9: same value keeps the halt, a new value clears it
    cfg_write(2, bnd_m);
    @(negedge clk);
    chk("R9 same value keeps halt", halted == 1'b1, int'(halted), 1);
    bnd_m = step(cur_m, NPG - 1);
    cfg_write(2, bnd_m);
    @(negedge clk);
    chk("R9 move clears halt", halted == 1'b0, int'(halted), 0);
    good_frame(300, 8'h44, 4, 1'b1);

    // R9: overrun and boundary move in the same cycle
    cfg_write(2, cur_m);
    bnd_m = step(cur_m, NPG - 1);
    w0 = we_cnt; o0 = ovw_cnt;
    send_frame(50, 0, 1'b0, 6, 1'b1, bnd_m);
    chk("R9 set wins", halted == 1'b1, int'(halted), 1);
    chk("R9 ovw same cycle", ovw_cnt - o0 == 1, ovw_cnt - o0, 1);
    chk("R9 boundary taken", int'(bnd_page) == bnd_m, int'(bnd_page), bnd_m);
    chk("R9 nothing stored", we_cnt == w0, we_cnt - w0, 0);
    cfg_write(2, step(cur_m, NPG - 2));
    @(negedge clk);
    chk("R9 later release", halted == 1'b0, int'(halted), 0);
    cfg_write(2, bnd_m);

    // R10: monitor mode
    cfg_write(4, 1);
    w0 = we_cnt; m0 = miss_cnt; p0 = pkt_cnt;
    send_frame(300, 0, 1'b0, 7, 1'b0, 0);
    chk("R10 no writes", we_cnt == w0, we_cnt - w0, 0);
    chk("R10 miss_pulse", miss_cnt - m0 == 1, miss_cnt - m0, 1);
    chk("R10 no pkt, cur kept", pkt_cnt == p0 && int'(cur_page) == cur_m, int'(cur_page), cur_m);
    cfg_write(4, 0);

    // R6: errored frame
    watch_pg = cur_m;
    w0 = we_cnt; p0 = pkt_cnt; h0 = hdrw_cnt;
    send_frame(20, 8'hF0, 1'b1, 8, 1'b0, 0);
    chk("R6 no pkt_pulse", pkt_cnt == p0, pkt_cnt - p0, 0);
    chk("R6 cur kept", int'(cur_page) == cur_m, int'(cur_page), cur_m);
    chk("R6 no header", hdrw_cnt == h0, hdrw_cnt - h0, 0);
    chk("R6 payload bytes", we_cnt - w0 == 20, we_cnt - w0, 20);
    watch_pg = -1;
    good_frame(40, 8'h02, 12, 1'b1);

    chk("R2 writes inside ring", outside_cnt == 0, outside_cnt, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule